// File: doc/BRIEF.md
# Startup Output-Short Detection Sequencer

This block gates the power stage of a bridge amplifier at power-up. Once logic power is reported good, it runs a two-phase check of every output before the half bridges may switch. First it looks for outputs shorted to ground, then for outputs shorted to the positive rail. While either phase is running, all half bridges are held in high impedance and the fault flag is pulled low. A short that the comparators keep reporting makes the sequencer go back to the ground phase, and it keeps doing so until the short is gone. After both phases pass, the bridges are released and a startup-complete level rises.

Each phase lasts a programmable number of clock cycles, which stands in for the time needed to charge the output filter capacitance. Comparator reports are ignored until a programmable settle count has elapsed within the phase. A short is declared only when one output reports it on a fixed number of consecutive samples. The sequencer runs once per power cycle. It skips both phases in single-ended mode. It ignores reset requests while a phase is running. A reset request after startup holds the outputs off but does not start a new check. Only a drop of power-good re-arms the check.

Top module: `short_scan_seq`

## Requirements
- R1: With rst_n high, a rising pwr_good in bridged modes (mode 2'b00, 2'b01 or 2'b11) raises drv_gnd at the next clock edge. No detection pass starts for any other reason.
- R2: A clean pass holds drv_gnd high for exactly max(step_len,1) cycles and then drv_sup for exactly max(step_len,1) cycles. start_done rises in the cycle right after the last drv_sup cycle.
- R3: A comparator bit is sampled only in phase cycles whose index (counted from 0 at phase entry) is at least settle. A short is declared when the same output reports 1 on QUAL consecutive sampled cycles. Shorter runs, and reports during the settle window, have no effect.
- R4: A declared short in either phase sends the sequencer back to cycle 0 of the ground phase. The bridges stay in high impedance until a full clean pass completes.
- R5: fault_n is 0 exactly while drv_gnd or drv_sup is 1, and 1 otherwise.
- R6: reset_req has no effect while a phase is running. The pass completes with the same timing as without it.
- R7: After startup, reset_req=1 gives hiz=1 and start_done=0 from the next cycle and drives neither test enable. One cycle after reset_req returns to 0, start_done is 1 again, with no new detection pass.
- R8: In single-ended mode (mode 2'b10), a rising pwr_good raises start_done at the next edge and neither test enable is ever driven.
- R9: hiz is always the complement of start_done. drv_gnd and drv_sup are never both 1, and neither is 1 while start_done is 1.
- R10: Comparator activity after startup does not change start_done, hiz or the test enables.
- R11: pwr_good=0 forces hiz=1, start_done=0 and fault_n=1 from the next cycle, and re-arms detection for the next rise of pwr_good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwr_good | input | 1 | Logic power good; its rise triggers detection |
| reset_req | input | 1 | Device reset request |
| mode | input | 2 | Output configuration: 00 bridged, 01 parallel bridged, 10 single-ended, 11 bridged |
| settle | input | CW | Phase cycles ignored before comparator sampling |
| step_len | input | CW | Length of each phase in cycles |
| cmp_gnd | input | NOUT | Per-output short-to-ground comparator, 1 = short |
| cmp_sup | input | NOUT | Per-output short-to-supply comparator, 1 = short |
| hiz | output | 1 | Hold all half bridges in high impedance |
| fault_n | output | 1 | Active-low fault flag, low during detection |
| drv_gnd | output | 1 | Ground-phase test drive enable |
| drv_sup | output | 1 | Supply-phase test drive enable |
| start_done | output | 1 | Startup complete, bridges released |

## Verification
The bench goes after the qualification edges. A report run one sample shorter than QUAL must leave the ground phase at its nominal length, and a run of exactly QUAL must lengthen it by the restart. A design that counted settle-window samples, or that declared a short one sample early, would change these phase lengths. A short in the supply phase must send the sequencer back to the ground phase; a design that only retried the supply phase would show a single ground phase. The bench also holds reset_req across a whole pass, pulses it after startup, and drives comparators after release. A design that honoured reset during the test, reran detection after reset, or let a late short reach the bridges would show extra test-enable cycles or a dropped start_done. Single-ended mode and zero step lengths check the skip path and the minimum phase length.

// File: rtl/short_scan_pkg.sv
package short_scan_pkg;

  typedef enum logic [2:0] {
    ST_OFF = 3'd0,
    ST_GND = 3'd1,
    ST_SUP = 3'd2,
    ST_RUN = 3'd3,
    ST_RST = 3'd4
  } scan_state_t;

  localparam logic [1:0] MODE_SE = 2'b10;

endpackage

// File: rtl/short_scan_rsync.sv
module short_scan_rsync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/short_scan_qual.sv
module short_scan_qual #(
  parameter int NOUT = 4,
  parameter int QUAL = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            sample_en,
  input  logic [NOUT-1:0] flags,
  output logic            short_det
);

  localparam int RW = (QUAL < 2) ? 1 : $clog2(QUAL + 1);
  localparam logic [RW-1:0] LIM = RW'(QUAL - 1);

  logic [NOUT-1:0] hit;

  for (genvar i = 0; i < NOUT; i++) begin : g_ch
    logic [RW-1:0] run_q, run_d;
    logic          run_en;

    assign hit[i]  = sample_en && flags[i] && (run_q == LIM);
    assign run_en  = clr || sample_en;

    always_comb begin
      run_d = run_q;
      if (clr)            run_d = '0;
      else if (flags[i])  run_d = run_q + RW'(1);
      else                run_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      run_q <= '0;
      else if (run_en) run_q <= run_d;
    end
  end

  assign short_det = |hit;

  // R3
  short_needs_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    short_det |-> sample_en);

endmodule

// File: rtl/short_scan_fsm.sv
module short_scan_fsm
  import short_scan_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_good,
  input  logic          reset_req,
  input  logic [1:0]    mode,
  input  logic [CW-1:0] settle,
  input  logic [CW-1:0] step_len,
  input  logic          short_det,
  output logic          sample_en,
  output logic          step_clr,
  output logic          hiz,
  output logic          fault_n,
  output logic          drv_gnd,
  output logic          drv_sup,
  output logic          start_done
);

  scan_state_t   state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          in_step, last, cnt_en;

  assign in_step   = (state_q == ST_GND) || (state_q == ST_SUP);
  assign last      = ({1'b0, cnt_q} + (CW+1)'(1)) >= {1'b0, step_len};
  assign sample_en = in_step && (cnt_q >= settle);
  assign cnt_en    = in_step || (cnt_q != '0);

  always_comb begin
    state_d  = state_q;
    cnt_d    = '0;
    done_d   = done_q;
    step_clr = 1'b1;
    if (!pwr_good) begin
      state_d = ST_OFF;
      done_d  = 1'b0;
    end else begin
      unique case (state_q)
        ST_OFF: begin
          if (mode == MODE_SE) begin
            state_d = ST_RUN;
            done_d  = 1'b1;
          end else begin
            state_d = ST_GND;
          end
        end
        ST_GND, ST_SUP: begin
          if (short_det) begin
            state_d = ST_GND;
          end else if (last) begin
            if (state_q == ST_GND) begin
              state_d = ST_SUP;
            end else begin
              state_d = ST_RUN;
              done_d  = 1'b1;
            end
          end else begin
            cnt_d    = cnt_q + CW'(1);
            step_clr = 1'b0;
          end
        end
        ST_RUN: begin
          if (reset_req) state_d = ST_RST;
        end
        ST_RST: begin
          if (!reset_req) state_d = done_q ? ST_RUN : ST_GND;
        end
        default: state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign start_done = (state_q == ST_RUN);
  assign hiz        = (state_q != ST_RUN);
  assign fault_n    = !in_step;
  assign drv_gnd    = (state_q == ST_GND);
  assign drv_sup    = (state_q == ST_SUP);

  // R2
  sup_after_gnd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SUP) |-> ($past(state_q) == ST_GND || $past(state_q) == ST_SUP));

  // R4
  short_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_step && short_det && pwr_good) |=> (state_q == ST_GND && cnt_q == '0));

  // R7
  rst_only_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RST) |-> ($past(state_q) == ST_RUN || $past(state_q) == ST_RST));

  // R9
  one_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({drv_gnd, drv_sup, start_done}));

  // R10
  run_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_done && pwr_good && !reset_req) |=> start_done);

  // R11
  off_on_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (hiz && fault_n && !start_done));

endmodule

// File: rtl/short_scan_seq.sv
module short_scan_seq #(
  parameter int NOUT = 4,
  parameter int CW   = 16,
  parameter int QUAL = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwr_good,
  input  logic            reset_req,
  input  logic [1:0]      mode,
  input  logic [CW-1:0]   settle,
  input  logic [CW-1:0]   step_len,
  input  logic [NOUT-1:0] cmp_gnd,
  input  logic [NOUT-1:0] cmp_sup,
  output logic            hiz,
  output logic            fault_n,
  output logic            drv_gnd,
  output logic            drv_sup,
  output logic            start_done
);

  logic            srst_n;
  logic            sample_en, step_clr, short_det;
  logic [NOUT-1:0] flags;

  short_scan_rsync u_rsync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  assign flags = drv_sup ? cmp_sup : cmp_gnd;

  short_scan_qual #(.NOUT(NOUT), .QUAL(QUAL)) u_qual (
    .clk       (clk),
    .rst_n     (srst_n),
    .clr       (step_clr),
    .sample_en (sample_en),
    .flags     (flags),
    .short_det (short_det)
  );

  short_scan_fsm #(.CW(CW)) u_fsm (
    .clk        (clk),
    .rst_n      (srst_n),
    .pwr_good   (pwr_good),
    .reset_req  (reset_req),
    .mode       (mode),
    .settle     (settle),
    .step_len   (step_len),
    .short_det  (short_det),
    .sample_en  (sample_en),
    .step_clr   (step_clr),
    .hiz        (hiz),
    .fault_n    (fault_n),
    .drv_gnd    (drv_gnd),
    .drv_sup    (drv_sup),
    .start_done (start_done)
  );

  // R5
  fault_tracks_test_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (!fault_n) == (drv_gnd || drv_sup));

  // R9
  hiz_vs_done_chk: assert property (@(posedge clk) disable iff (!srst_n)
    hiz == !start_done);

endmodule

// File: tb/sim_short_scan_seq.sv
module sim_short_scan_seq;

  localparam int NOUT = 4;
  localparam int CW   = 16;
  localparam int QUAL = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            pwr_good = 1'b0;
  logic            reset_req = 1'b0;
  logic [1:0]      mode = 2'b00;
  logic [CW-1:0]   settle = '0;
  logic [CW-1:0]   step_len = '0;
  logic [NOUT-1:0] cmp_gnd = '0;
  logic [NOUT-1:0] cmp_sup = '0;
  logic hiz, fault_n, drv_gnd, drv_sup, start_done;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #2 clk = ~clk;

  short_scan_seq #(.NOUT(NOUT), .CW(CW), .QUAL(QUAL)) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .reset_req(reset_req),
    .mode(mode), .settle(settle), .step_len(step_len),
    .cmp_gnd(cmp_gnd), .cmp_sup(cmp_sup), .hiz(hiz), .fault_n(fault_n),
    .drv_gnd(drv_gnd), .drv_sup(drv_sup), .start_done(start_done)
  );

  // {mode, step_len, settle}
  localparam logic [33:0] VEC [6] = '{
    {2'b00, 16'd40, 16'd10},
    {2'b01, 16'd25, 16'd5},
    {2'b10, 16'd40, 16'd10},
    {2'b11, 16'd1,  16'd0},
    {2'b00, 16'd0,  16'd0},
    {2'b00, 16'd8,  16'd8}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic power_cycle();
    @(negedge clk);
    pwr_good = 1'b0;
    repeat (3) @(negedge clk);
    chk(hiz && !start_done && fault_n, "R11 off state", {hiz, start_done, fault_n}, 3'b101);
    pwr_good = 1'b1;
  endtask

  // ph: 0 none, 1 ground phase, 2 supply phase; st/ln index window within phase
  task automatic scan(input int ph, input int st, input int ln, input int bitn, input bit rq,
                      output int ng, output int ns, output int nf, output int nc, output int nbad);
    int guard = 0;
    ng = 0; ns = 0; nf = 0; nc = 0; nbad = 0;
    reset_req = rq;
    while (!start_done && guard < 20000) begin
      @(negedge clk);
      guard++;
      nc++;
      if (drv_gnd) ng++;
      if (drv_sup) ns++;
      if (!fault_n) nf++;
      if ((hiz !== !start_done) || (drv_gnd && drv_sup)) nbad++;
      cmp_gnd = '0;
      cmp_sup = '0;
      if (ph == 1 && drv_gnd && (ng - 1) >= st && (ng - 1) < st + ln) cmp_gnd[bitn] = 1'b1;
      if (ph == 2 && drv_sup && (ns - 1) >= st && (ns - 1) < st + ln) cmp_sup[bitn] = 1'b1;
    end
    cmp_gnd = '0;
    cmp_sup = '0;
    reset_req = 1'b0;
    chk(guard < 20000, "R4 scan finished", guard, 20000);
  endtask

  task automatic setup(input logic [1:0] m, input int len, input int stl);
    mode = m;
    step_len = CW'(len);
    settle = CW'(stl);
  endtask

  initial begin
    int ng, ns, nf, nc, nb;
    repeat (3) @(negedge clk);
    chk(hiz && !start_done && fault_n && !drv_gnd && !drv_sup, "R11 reset state",
        {hiz, start_done, fault_n, drv_gnd, drv_sup}, 5'b10100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int v = 0; v < 6; v++) begin
      int len, el, eg;
      setup(VEC[v][33:32], int'(VEC[v][31:16]), int'(VEC[v][15:0]));
      power_cycle();
      scan(0, 0, 0, 0, 1'b0, ng, ns, nf, nc, nb);
      len = int'(VEC[v][31:16]);
      el  = (len < 1) ? 1 : len;
      eg  = (VEC[v][33:32] == 2'b10) ? 0 : el;
      chk(ng == eg, (eg == 0) ? "R8 no ground drive" : "R1 ground length", ng, eg);
      chk(ns == eg, "R2 supply length", ns, eg);
      chk(nf == 2 * eg, "R5 fault low span", nf, 2 * eg);
      chk(nc == 2 * eg + 1, "R2 start latency", nc, 2 * eg + 1);
      chk(nb == 0, "R9 output coherence", nb, 0);
    end

    setup(2'b00, 40, 10);
    power_cycle();
    scan(1, 12, QUAL - 1, 2, 1'b0, ng, ns, nf, nc, nb);
    chk(ng == 40, "R3 short run ignored", ng, 40);

    power_cycle();
    scan(1, 12, QUAL, 2, 1'b0, ng, ns, nf, nc, nb);
    chk(ng == 55, "R3 qualified short restarts", ng, 55);
    chk(ns == 40, "R4 supply after restart", ns, 40);

    power_cycle();
    scan(1, 0, 10, 1, 1'b0, ng, ns, nf, nc, nb);
    chk(ng == 40, "R3 settle window masked", ng, 40);

    power_cycle();
    scan(2, 10, QUAL, 3, 1'b0, ng, ns, nf, nc, nb);
    chk(ng == 80, "R4 supply short back to ground", ng, 80);
    chk(ns == 53, "R4 supply length with restart", ns, 53);

    // held short: 23 restarts of 13 cycles, then a clean 40-cycle pass
    power_cycle();
    scan(1, 0, 300, 1, 1'b0, ng, ns, nf, nc, nb);
    chk(ng == 339, "R4 held short keeps retesting", ng, 339);
    chk(nf == 379, "R5 fault low while held", nf, 379);
    chk(nb == 0, "R9 hiz held during short", nb, 0);

    power_cycle();
    scan(0, 0, 0, 0, 1'b1, ng, ns, nf, nc, nb);
    chk(ng == 40 && ns == 40, "R6 reset ignored during test", ng + ns, 80);

    @(negedge clk);
    reset_req = 1'b1;
    @(negedge clk);
    chk(hiz && !start_done && fault_n, "R7 reset holds off", {hiz, start_done, fault_n}, 3'b101);
    ng = 0;
    repeat (5) begin
      @(negedge clk);
      if (drv_gnd || drv_sup) ng++;
    end
    reset_req = 1'b0;
    @(negedge clk);
    chk(start_done && !hiz, "R7 release without rescan", start_done, 1);
    chk(ng == 0, "R7 no test drive in reset", ng, 0);

    ng = 0;
    cmp_gnd = '1;
    cmp_sup = '1;
    repeat (50) begin
      @(negedge clk);
      if (!start_done || hiz || drv_gnd || drv_sup) ng++;
    end
    cmp_gnd = '0;
    cmp_sup = '0;
    chk(ng == 0, "R10 late short ignored", ng, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule